// File: doc/BRIEF.md
# Vector Mask Compress/Expand Unit

This block moves elements between a source vector register and a destination vector register under the control of a per-element mask. In compress mode it gathers the source elements whose mask bit is set and writes them one after another into the destination, starting at element 0. The total number of elements written is the number of set mask bits inside the active length. In expand mode it does the reverse. Source elements are taken in order, and each one is written to the position of the next set mask bit. Positions whose mask bit is clear are left as they were.

A request is given by a one-cycle `start` pulse with a mode, a vector length and a mask. The unit then scans one mask bit per cycle, from element 0 upward. It reads the source register through a combinational read port and writes the destination register through a write port with an enable. Two running counters set the addresses. One is the element index, which steps every cycle. The other is the set-bit count, which steps only when the current mask bit is 1. The compress destination address and the expand source address both come from the set-bit count. When the scan ends, `done` pulses for one cycle and `pop_count` holds the number of set bits found.

Top module: `vcx_unit`

## Requirements
- R1: After reset, `busy`, `done` and `dst_we` are 0 and `pop_count` is 0.
- R2: In compress mode (`mode` = 0), the source element at each set mask bit below the active length is written to destination element k. Here k is the number of set bits below that position, so results fill positions 0, 1, 2 and so on in ascending source order.
- R3: When `done` is high, `pop_count` equals the number of 1 bits in `mask[vl-1:0]`.
- R4: In expand mode (`mode` = 1), source element k is written to the destination position of the k-th set mask bit, counting from 0 and starting at the lowest position.
- R5: No write enable is given for an element whose mask bit is clear. After compress, destination elements at or above `pop_count` keep their old values. After expand, positions with a clear mask bit keep their old values.
- R6: A request with length vl ≥ 1 that is accepted on a clock edge keeps `busy` high for exactly vl cycles. `done` is high for the single cycle after that.
- R7: Mask bits at or above the active length have no effect on writes or on `pop_count`.
- R8: A request with vl = 0 makes no writes and raises `done` in the cycle right after it is accepted, with `pop_count` equal to 0.
- R9: A `start` pulse that arrives while `busy` is high is ignored, and the operation already running finishes unchanged.
- R10: A vl larger than NELEM is treated as NELEM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, accepted only while idle |
| mode | input | 1 | 0 = compress, 1 = expand |
| vl | input | $clog2(NELEM)+1 | Active vector length |
| mask | input | NELEM | One mask bit per element |
| src_addr | output | $clog2(NELEM) | Source register read index |
| src_data | input | EW | Source element read combinationally at `src_addr` |
| dst_we | output | 1 | Destination write enable |
| dst_addr | output | $clog2(NELEM) | Destination write index |
| dst_data | output | EW | Destination write data |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | One-cycle pulse at the end of the scan |
| pop_count | output | $clog2(NELEM)+1 | Running count of set bits, final when `done` is high |

## Verification
The bench aims at cases where the set-bit counter and the element counter can get mixed up. These are sparse masks, all-zero masks, all-one masks, and mask bits set just above the active length. Swapping the two counters in one mode would scatter a compress result or pack an expand result, and the full destination compare would show this. A design that writes elements with a clear mask bit, or that keeps scanning past vl, would overwrite preset destination contents or raise `pop_count`. The bench also checks three timing cases: vl = 0, vl above NELEM, and a second `start` during a scan. These catch an off-by-one in the stop condition, a missing length clamp, and a request that restarts a scan already running.

// File: rtl/vcx_pkg.sv
package vcx_pkg;
    typedef enum logic {
        VCX_COMPRESS = 1'b0,
        VCX_EXPAND   = 1'b1
    } vcx_mode_e;
endpackage

// File: rtl/vcx_scan_ctrl.sv
module vcx_scan_ctrl
    import vcx_pkg::*;
#(
    parameter int NELEM = 16,
    localparam int IDXW = $clog2(NELEM),
    localparam int CNTW = IDXW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  vcx_mode_e       mode_in,
    input  logic [CNTW-1:0] vl_in,
    input  logic [NELEM-1:0] mask_in,
    output logic            busy,
    output logic            done,
    output vcx_mode_e       mode_q_o,
    output logic [IDXW-1:0] elem_idx,
    output logic [CNTW-1:0] set_cnt,
    output logic            cur_bit
);
    localparam logic [CNTW-1:0] VL_MAX = CNTW'(NELEM);

    typedef struct packed {
        logic             busy;
        logic             done;
        vcx_mode_e        mode;
        logic [CNTW-1:0]  vl;
        logic [NELEM-1:0] mask;
        logic [CNTW-1:0]  elem;
        logic [CNTW-1:0]  cnt;
    } scan_state_t;

    scan_state_t s_d, s_q;
    logic [CNTW-1:0] vl_eff;
    logic [CNTW-1:0] elem_nxt;

    always_comb begin
        vl_eff   = (vl_in > VL_MAX) ? VL_MAX : vl_in;
        elem_nxt = s_q.elem + CNTW'(1);
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.mode = mode_in;
                s_d.mask = mask_in;
                s_d.vl   = vl_eff;
                s_d.elem = '0;
                s_d.cnt  = '0;
                if (vl_eff == '0) begin
                    s_d.done = 1'b1;
                end else begin
                    s_d.busy = 1'b1;
                end
            end
        end else begin
            if (s_q.mask[s_q.elem[IDXW-1:0]]) begin
                s_d.cnt = s_q.cnt + CNTW'(1);
            end
            s_d.elem = elem_nxt;
            if (elem_nxt == s_q.vl) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{busy: 1'b0, done: 1'b0, mode: VCX_COMPRESS,
                     vl: '0, mask: '0, elem: '0, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = s_q.busy;
    assign done     = s_q.done;
    assign mode_q_o = s_q.mode;
    assign elem_idx = s_q.elem[IDXW-1:0];
    assign set_cnt  = s_q.cnt;
    assign cur_bit  = s_q.mask[s_q.elem[IDXW-1:0]];
endmodule

// File: rtl/vcx_port_route.sv
module vcx_port_route
    import vcx_pkg::*;
#(
    parameter int NELEM = 16,
    parameter int EW    = 16,
    localparam int IDXW = $clog2(NELEM),
    localparam int CNTW = IDXW + 1
) (
    input  logic            busy,
    input  vcx_mode_e       mode_q,
    input  logic [IDXW-1:0] elem_idx,
    input  logic [CNTW-1:0] set_cnt,
    input  logic            cur_bit,
    input  logic [EW-1:0]   src_data,
    output logic [IDXW-1:0] src_addr,
    output logic            dst_we,
    output logic [IDXW-1:0] dst_addr,
    output logic [EW-1:0]   dst_data
);
    always_comb begin
        if (mode_q == VCX_EXPAND) begin
            src_addr = set_cnt[IDXW-1:0];
            dst_addr = elem_idx;
        end else begin
            src_addr = elem_idx;
            dst_addr = set_cnt[IDXW-1:0];
        end
        dst_we   = busy & cur_bit;
        dst_data = src_data;
    end
endmodule

// File: rtl/vcx_unit.sv
module vcx_unit
    import vcx_pkg::*;
#(
    parameter int NELEM = 16,
    parameter int EW    = 16,
    localparam int IDXW = $clog2(NELEM),
    localparam int CNTW = IDXW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode,
    input  logic [CNTW-1:0]  vl,
    input  logic [NELEM-1:0] mask,
    output logic [IDXW-1:0]  src_addr,
    input  logic [EW-1:0]    src_data,
    output logic             dst_we,
    output logic [IDXW-1:0]  dst_addr,
    output logic [EW-1:0]    dst_data,
    output logic             busy,
    output logic             done,
    output logic [CNTW-1:0]  pop_count
);
    vcx_mode_e       run_mode;
    logic [IDXW-1:0] elem_idx;
    logic [CNTW-1:0] set_cnt;
    logic            cur_bit;

    vcx_scan_ctrl #(.NELEM(NELEM)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mode_in  (vcx_mode_e'(mode)),
        .vl_in    (vl),
        .mask_in  (mask),
        .busy     (busy),
        .done     (done),
        .mode_q_o (run_mode),
        .elem_idx (elem_idx),
        .set_cnt  (set_cnt),
        .cur_bit  (cur_bit)
    );

    vcx_port_route #(.NELEM(NELEM), .EW(EW)) u_route (
        .busy     (busy),
        .mode_q   (run_mode),
        .elem_idx (elem_idx),
        .set_cnt  (set_cnt),
        .cur_bit  (cur_bit),
        .src_data (src_data),
        .src_addr (src_addr),
        .dst_we   (dst_we),
        .dst_addr (dst_addr),
        .dst_data (dst_data)
    );

    assign pop_count = set_cnt;
endmodule

// File: rtl/vcx_unit_chk.sv
module vcx_unit_chk #(
    parameter int NELEM = 16,
    localparam int IDXW = $clog2(NELEM),
    localparam int CNTW = IDXW + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic            dst_we,
    input logic [IDXW-1:0] dst_addr,
    input logic [IDXW-1:0] src_addr,
    input logic            run_mode,
    input logic [CNTW-1:0] pop_count
);
    a_r5_we_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |-> busy);

    a_r2_compress_dst_not_ahead: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_we && !run_mode) |-> (dst_addr <= src_addr));

    a_r4_expand_src_not_ahead: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_we && run_mode) |-> (src_addr <= dst_addr));

    a_r2_compress_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && dst_we && $past(dst_we) && !run_mode)
        |-> (dst_addr == $past(dst_addr) + IDXW'(1)));

    a_r6_end_of_scan_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pop_count <= CNTW'(NELEM)));
endmodule

bind vcx_unit vcx_unit_chk #(.NELEM(NELEM)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .dst_we    (dst_we),
    .dst_addr  (dst_addr),
    .src_addr  (src_addr),
    .run_mode  (run_mode),
    .pop_count (pop_count)
);

// File: tb/vcx_unit_tb.sv
module vcx_unit_tb;
    localparam int NELEM = 16;
    localparam int EW    = 16;
    localparam int IDXW  = $clog2(NELEM);
    localparam int CNTW  = IDXW + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             mode = 1'b0;
    logic [CNTW-1:0]  vl = '0;
    logic [NELEM-1:0] mask = '0;
    logic [IDXW-1:0]  src_addr;
    logic [EW-1:0]    src_data;
    logic             dst_we;
    logic [IDXW-1:0]  dst_addr;
    logic [EW-1:0]    dst_data;
    logic             busy;
    logic             done;
    logic [CNTW-1:0]  pop_count;

    logic [EW-1:0] src_mem [NELEM];
    logic [EW-1:0] dst_mem [NELEM];
    logic          load = 1'b0;
    logic [EW-1:0] fill_base = '0;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    vcx_unit #(.NELEM(NELEM), .EW(EW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .vl(vl),
        .mask(mask), .src_addr(src_addr), .src_data(src_data),
        .dst_we(dst_we), .dst_addr(dst_addr), .dst_data(dst_data),
        .busy(busy), .done(done), .pop_count(pop_count)
    );

    assign src_data = src_mem[src_addr];

    always @(posedge clk) begin
        if (load) begin
            for (int i = 0; i < NELEM; i++) dst_mem[i] <= fill_base + EW'(i);
        end else if (dst_we) begin
            dst_mem[dst_addr] <= dst_data;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input bit md, input int vl_req, input logic [NELEM-1:0] m,
                          input bit disturb, input string tag);
        logic [EW-1:0] exp_mem [NELEM];
        int vle, k, n;
        bit seen;
        vle = (vl_req > NELEM) ? NELEM : vl_req;
        for (int i = 0; i < NELEM; i++) src_mem[i] = EW'($urandom);
        fill_base = EW'($urandom);
        for (int i = 0; i < NELEM; i++) exp_mem[i] = fill_base + EW'(i);
        k = 0;
        for (int i = 0; i < vle; i++) begin
            if (m[i]) begin
                if (!md) exp_mem[k] = src_mem[i];
                else     exp_mem[i] = src_mem[k];
                k++;
            end
        end
        @(negedge clk);
        load = 1'b1;
        @(negedge clk);
        load  = 1'b0;
        start = 1'b1;
        mode  = md;
        vl    = CNTW'(vl_req);
        mask  = m;
        n = 0;
        seen = 1'b0;
        while (!seen && n < 100) begin
            @(negedge clk);
            n++;
            start = 1'b0;
            if (disturb && n == 2) begin
                start = 1'b1;
                mode  = ~md;
                vl    = CNTW'(3);
                mask  = ~m;
            end
            if (done) seen = 1'b1;
        end
        start = 1'b0;
        check(seen && n == vle + 1, {"R6 latency ", tag}, n, vle + 1);
        check(int'(pop_count) == k, {"R3 count ", tag}, int'(pop_count), k);
        @(negedge clk);
        for (int i = 0; i < NELEM; i++) begin
            check(dst_mem[i] == exp_mem[i],
                  (exp_mem[i] == fill_base + EW'(i)) ? {"R5 kept ", tag}
                                                     : (md ? {"R4 expand ", tag} : {"R2 compress ", tag}),
                  int'(dst_mem[i]), int'(exp_mem[i]));
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd9137));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !dst_we && pop_count == '0, "R1 reset state",
              {busy, done, dst_we}, 0);
        run_op(1'b0, 8, 16'h00B5, 1'b0, "R2");
        run_op(1'b1, 8, 16'h00B5, 1'b0, "R4");
        run_op(1'b0, 16, 16'hFFFF, 1'b0, "R2 full");
        run_op(1'b1, 16, 16'h0000, 1'b0, "R5 empty");
        run_op(1'b0, 5, 16'hFFE0, 1'b0, "R7");
        run_op(1'b1, 5, 16'hFFE2, 1'b0, "R7");
        run_op(1'b0, 0, 16'hFFFF, 1'b0, "R8");
        run_op(1'b1, 0, 16'hFFFF, 1'b0, "R8");
        run_op(1'b0, 8, 16'h0095, 1'b1, "R9");
        run_op(1'b1, 19, 16'hA5C3, 1'b0, "R10");
        run_op(1'b1, 1, 16'h0001, 1'b0, "R6 single");
        for (int t = 0; t < 40; t++) begin
            run_op(1'($urandom), int'($urandom_range(0, NELEM + 2)),
                   NELEM'($urandom), 1'b0, "random");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule